// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates among up to 28 level-sensitive interrupt request lines. Each line is gated by an enable mask. Every source except source 0 carries a programmable 3-bit priority level. Once per clock the controller picks the active, enabled source with the highest level and registers its number. It then presents a 32-bit vector word. That word joins a software-programmed 16-bit base address with the winner's index, so a handler can load the service-routine pointer from memory without scanning status bits.

A small register bus holds a nesting-enable bit, the base register, four packed priority registers and the read-only vector. Priority fields sit four bits apart. In the priority register at word `3+k`, source `8k+n` owns bits `4n+2:4n`. The top bit of each nibble is unused, and so is the source-0 nibble. Firmware should only use the vector while the nesting bit is set.

Top module: `vpic`

## Requirements
- R1: The registered winner is the active (`irq_req & irq_en`) source with the numerically largest priority level.
- R2: Among active sources of equal level the lowest source number wins. Source 0 has no priority field and always competes at level 0.
- R3: The vector word has bits 31:23 = 0, bits 22:7 = base register bits 15:0, bits 6:2 = winning source number (for example source 4 gives 00100), and bits 1:0 = 0. It is readable at word address 2 and on the `vector` port.
- R4: When no enabled source is active, the source field of the vector is 0 one clock later and `irq` is low.
- R5: `irq` is the combinational OR of `irq_req & irq_en` and follows the inputs in the same cycle.
- R6: The vector's source field changes at the first rising clock edge after a request, enable or priority change, and not before it.
- R7: Word address `3+k` (k = 0..3) reads and writes the priority levels of sources `8k+n` in bits `4n+2:4n`.
- R8: Written values in reserved positions are ignored and read as 0. These positions are: bit `4n+3` of each priority nibble, the source-0 nibble, the nibbles of sources 28 and above, base bits 31:16, and nesting bits 31:1.
- R9: After reset, every register and the vector read 0x00000000.
- R10: Bit 0 at word address 0 is the nesting enable. It reads back there and drives `nest_en`.
- R11: The vector at word address 2 is read-only, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 28 | Level interrupt requests, bit i = source i |
| irq_en | input | 28 | Per-source enable mask |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: 0 nest, 1 base, 2 vector, 3..6 priority |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| vector | output | 32 | Current vector word |
| irq | output | 1 | Any enabled request active |
| nest_en | output | 1 | Nesting enable bit |

## Verification
`irq` and `bus_rdata` are combinational, so the bench checks them a short delay after driving the inputs, before any clock edge. The vector's source field and each register write take effect at the next rising edge. The bench therefore drives on the falling edge and samples after the following falling edge. For R6 it also confirms that the old value is still present just before that edge. A bench model computes the expected winner from its own shadow of the written priority levels.

// File: rtl/vpic.sv
module vpic #(
  parameter int NUM_SRC = 28,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               bus_we,
  input  logic [2:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [31:0]        vector,
  output logic               irq,
  output logic               nest_en
);
  localparam int IDX_W  = 5;
  localparam int BASE_W = 16;
  localparam int NPRIO  = (NUM_SRC + 7) / 8;
  localparam logic [2:0] A_NEST = 3'd0;
  localparam logic [2:0] A_BASE = 3'd1;
  localparam logic [2:0] A_VEC  = 3'd2;
  localparam logic [2:0] A_PRIO = 3'd3;

  function automatic logic [31:0] prio_mask(int k);
    logic [31:0] m;
    m = '0;
    for (int n = 0; n < 8; n++)
      if (8*k + n >= 1 && 8*k + n < NUM_SRC) m[4*n +: PRIO_W] = '1;
    return m;
  endfunction

  logic [31:0]        prio_q [NPRIO];
  logic [BASE_W-1:0]  base_q;
  logic               nest_q;
  logic [IDX_W-1:0]   win_q, win_d;
  logic [NUM_SRC-1:0] masked;

  assign masked  = irq_req & irq_en;
  assign irq     = |masked;
  assign nest_en = nest_q;
  assign vector  = {9'd0, base_q, win_q, 2'b00};

  always_comb begin
    logic [PRIO_W-1:0] best_lvl, lvl;
    logic found;
    best_lvl = '0;
    found    = 1'b0;
    win_d    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      lvl = prio_q[i/8][(i%8)*4 +: PRIO_W];
      if (masked[i] && (!found || lvl > best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl;
        win_d    = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      nest_q <= 1'b0;
      win_q  <= '0;
      for (int k = 0; k < NPRIO; k++) prio_q[k] <= '0;
    end else begin
      win_q <= win_d;
      if (bus_we) begin
        if (bus_addr == A_NEST) nest_q <= bus_wdata[0];
        if (bus_addr == A_BASE) base_q <= bus_wdata[BASE_W-1:0];
        for (int k = 0; k < NPRIO; k++)
          if (bus_addr == A_PRIO + 3'(k)) prio_q[k] <= bus_wdata & prio_mask(k);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_NEST) bus_rdata = {31'd0, nest_q};
    if (bus_addr == A_BASE) bus_rdata = {{(32-BASE_W){1'b0}}, base_q};
    if (bus_addr == A_VEC)  bus_rdata = vector;
    for (int k = 0; k < NPRIO; k++)
      if (bus_addr == A_PRIO + 3'(k)) bus_rdata = prio_q[k];
  end

  logic [NUM_SRC-1:0] masked_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) masked_d <= '0;
    else        masked_d <= masked;

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |=> vector[6:2] == 5'd0);

  assert_winner_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vector[6:2] != 5'd0 |-> masked_d[vector[6:2]]);

  assert_base_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_addr == A_BASE) |-> vector[22:7] == $past(bus_wdata[15:0]));

  assert_nest_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_addr == A_NEST) |-> nest_en == $past(bus_wdata[0]));

  assert_prio_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == A_PRIO |-> (bus_rdata & 32'h8888_888F) == 32'd0);

  assert_vec_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_addr == A_VEC) |-> $stable(vector[22:7]));
endmodule

// File: tb/tb_vpic.sv
module tb_vpic;
  localparam int NS = 28;
  logic clk = 0, rst_n = 0;
  logic [NS-1:0] irq_req = '0, irq_en = '0;
  logic bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, vector;
  logic irq, nest_en;
  int errors = 0, checks = 0;
  int lvl [NS];
  logic [15:0] base_sh = '0;

  vpic dut (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
            .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
            .bus_rdata(bus_rdata), .vector(vector), .irq(irq), .nest_en(nest_en));

  always #4 clk = ~clk;

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] pmask(int k);
    logic [31:0] m = '0;
    for (int n = 0; n < 8; n++)
      if (8*k+n >= 1 && 8*k+n < NS) m[4*n +: 3] = 3'b111;
    return m;
  endfunction

  function automatic logic [4:0] exp_idx(logic [NS-1:0] r, logic [NS-1:0] e);
    int best = -1, bl = 0;
    for (int s = 0; s < NS; s++)
      if (r[s] && e[s] && (best < 0 || lvl[s] > bl)) begin
        best = s; bl = lvl[s];
      end
    return (best < 0) ? 5'd0 : 5'(best);
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    if (a == 1) base_sh = d[15:0];
    if (a >= 3)
      for (int n = 0; n < 8; n++)
        if (8*(a-3)+n >= 1 && 8*(a-3)+n < NS) lvl[8*(a-3)+n] = int'(d[4*n +: 3]);
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string r);
    bus_addr = a; #1;
    chk(r, bus_rdata, exp);
  endtask

  task automatic apply(logic [NS-1:0] r, logic [NS-1:0] e, string tag);
    logic [4:0] prev;
    @(negedge clk);
    prev = vector[6:2];
    irq_req = r; irq_en = e; #1;
    chk({tag, " R5 irq"}, 32'(irq), 32'(|(r & e)));
    chk({tag, " R6 before edge"}, 32'(vector[6:2]), 32'(prev));
    @(negedge clk);
    chk({tag, " R1 vector"}, vector, {9'd0, base_sh, exp_idx(r, e), 2'b00});
  endtask

  initial begin
    for (int s = 0; s < NS; s++) lvl[s] = 0;
    repeat (3) @(negedge clk);
    chk("R9 vector reset", vector, 32'd0);
    chk("R9 irq reset", 32'(irq), 32'd0);
    for (int a = 0; a < 7; a++) rd(3'(a), 32'd0, "R9 register reset");
    rst_n = 1;
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'd1, "R10/R8 nest readback");
    chk("R10 nest_en", 32'(nest_en), 32'd1);
    wr(0, 32'hFFFF_FFFE);
    chk("R10 nest_en clear", 32'(nest_en), 32'd0);
    wr(0, 32'd1);
    wr(1, 32'hFFFF_ABCD);
    rd(1, 32'h0000_ABCD, "R8 base reserved");
    rd(2, {9'd0, 16'hABCD, 5'd0, 2'b00}, "R3 vector base field");
    wr(2, 32'h1234_5678);
    rd(2, {9'd0, 16'hABCD, 5'd0, 2'b00}, "R11 vector read-only");
    for (int k = 0; k < 4; k++) begin
      wr(3'(3+k), 32'hFFFF_FFFF);
      rd(3'(3+k), pmask(k), "R8 priority reserved");
    end
    wr(3, 32'h0000_0000);
    wr(4, 32'h0000_0000);
    wr(5, 32'h0000_0000);
    wr(6, 32'h0000_0000);
    wr(3, 32'h0005_0000);
    rd(3, 32'h0005_0000, "R7 source 4 field");
    apply(28'h10, 28'hFFFFFFF, "timer2 R3");
    chk("R3 source 4 code", 32'(vector[6:2]), 32'b00100);
    wr(4, 32'h0000_0030);
    wr(5, 32'h0000_3000);
    apply((28'h1 << 9) | (28'h1 << 19), 28'hFFFFFFF, "tie R2");
    chk("R2 lower wins", 32'(vector[6:2]), 32'd9);
    apply(28'h9, 28'hFFFFFFF, "src0 level0 R2");
    chk("R2 source 0 wins", 32'(vector[6:2]), 32'd0);
    apply((28'h1 << 9) | 28'h10, 28'hFFFFFFF, "level R1");
    chk("R1 higher level", 32'(vector[6:2]), 32'd4);
    apply(28'hFFFFFFF, 28'h0, "masked R4");
    chk("R4 idle irq", 32'(irq), 32'd0);
    apply(28'h0, 28'hFFFFFFF, "none R4");
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 6) == 0) wr(3'(3 + $urandom % 4), $urandom);
      if (($urandom % 10) == 0) wr(1, $urandom);
      apply(28'($urandom) & 28'($urandom) & 28'($urandom), 28'($urandom), "random R1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'd2024));
endmodule